// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter

The arbiter looks at every interrupt source and, for each CPU interface, picks the best candidate. A candidate must be enabled and pending. A shared source must also name that CPU in its target mask. The best candidate is the one with the lowest numeric priority; on a tie, the lowest source number wins. The outcome is then gated per CPU. First, the CPU's priority mask decides whether the winner is reported as the highest pending ID. Second, the CPU's running priority and the two group enables decide whether an interrupt line is raised at all. A group-0 winner can be steered to the fast interrupt line.

Each source carries an enable bit, a pending bit, an 8-bit priority, a group bit and one target bit per CPU. Each CPU has a priority mask, a 9-bit running priority (0x100 means idle), two group enables and a FIQ-steering enable. The distributor adds two group enables of its own. Selection is combinational and one set of output registers follows it. A change on any input therefore shows at the outputs one clock later.

Top module: `irq_prio_arb`

## Requirements
- R1: While reset is asserted, every CPU has irq_o and fiq_o low and hp_id equal to 1023.
- R2: When no source qualifies for a CPU, that CPU's hp_id is 1023 and both of its lines are low. Any hp_id other than 1023 is a valid source number.
- R3: When dist_grp_en is 2'b00, or a CPU's two-bit slice of cpu_grp_en is 2'b00, that CPU's lines are low and its hp_id is 1023.
- R4: Sources 0 to 31 qualify for every CPU and ignore the target mask. A source s of 32 or above qualifies for CPU c only when src_target[s*NUM_CPU+c] is 1.
- R5: Among qualifying sources (src_enable and src_pending both 1), the lowest priority value src_prio[s*8+:8] wins. On equal priority, the lowest source number wins.
- R6: The winner is reported on hp_id only when its priority is strictly less than the CPU's priority mask. Otherwise hp_id is 1023 and both lines are low.
- R7: A line is raised only when the winner's priority is also strictly less than the CPU's 9-bit running priority. The value 0x100 is above every 8-bit priority.
- R8: A line is raised only when the winner's group g (src_group bit: 0 = group 0, 1 = group 1) is enabled in both dist_grp_en[g] and cpu_grp_en[c*2+g]. If the group is not enabled in both, the winner is still reported on hp_id.
- R9: When a line is raised, fiq_o is chosen if the winner is in group 0 and cpu_fiq_en[c] is 1. In every other case irq_o is chosen. irq_o and fiq_o are never high together.
- R10: All outputs are registered. An input change shows at the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_enable | input | NUM_SRC | Per-source enable |
| src_pending | input | NUM_SRC | Per-source pending |
| src_group | input | NUM_SRC | Per-source group (0 or 1) |
| src_prio | input | NUM_SRC*8 | Per-source priority, source s at [s*8+:8] |
| src_target | input | NUM_SRC*NUM_CPU | Target bits, source s CPU c at [s*NUM_CPU+c] |
| dist_grp_en | input | 2 | Distributor enable for group 0 (bit 0) and group 1 (bit 1) |
| cpu_grp_en | input | NUM_CPU*2 | Per-CPU group enables, CPU c at [c*2+:2] |
| cpu_fiq_en | input | NUM_CPU | Per-CPU steering of group 0 to FIQ |
| cpu_pmask | input | NUM_CPU*8 | Per-CPU priority mask |
| cpu_running | input | NUM_CPU*9 | Per-CPU running priority, 0x100 idle |
| irq_o | output | NUM_CPU | Per-CPU normal interrupt line |
| fiq_o | output | NUM_CPU | Per-CPU fast interrupt line |
| hp_id | output | NUM_CPU*10 | Per-CPU highest pending ID, 1023 when none |

## Verification
The assertions assume that the inputs are stable and free of X around each rising edge. They also treat each input value as a complete snapshot of state, with no handshake implied. The properties that use `|=>` rely on the input seen at one edge being the one the next registered output is built from.

The bench meets these assumptions by changing every input only at the falling edge. It holds each pattern for a full cycle before it samples.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int PRIO_W  = 8;
  localparam int RUN_W   = 9;
  localparam int ID_W    = 10;
  localparam int PRIV_N  = 32;
  localparam logic [ID_W-1:0]  NO_IRQ    = 10'd1023;
  localparam logic [RUN_W-1:0] PRIO_IDLE = 9'h100;

  typedef struct packed {
    logic [RUN_W-1:0] prio;
    logic [ID_W-1:0]  id;
    logic             grp;
  } winner_t;
endpackage

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]        en,
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC-1:0]        grp,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [NUM_SRC-1:0]        tgt_col,
  output winner_t                   win
);
  always_comb begin
    win.prio = PRIO_IDLE;
    win.id   = NO_IRQ;
    win.grp  = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (en[s] && pend[s] && (s < PRIV_N || tgt_col[s]) &&
          ({1'b0, prio[s*PRIO_W +: PRIO_W]} < win.prio)) begin
        win.prio = {1'b0, prio[s*PRIO_W +: PRIO_W]};
        win.id   = ID_W'(s);
        win.grp  = grp[s];
      end
    end
  end
endmodule

// File: rtl/arb_gate.sv
module arb_gate
  import arb_pkg::*;
(
  input  winner_t           win,
  input  logic [1:0]        dist_en,
  input  logic [1:0]        cpu_en,
  input  logic              fiq_en,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [RUN_W-1:0]  running,
  output logic              irq_d,
  output logic              fiq_d,
  output logic [ID_W-1:0]   hp_d
);
  logic grp_ok;
  logic line;

  assign grp_ok = dist_en[win.grp] && cpu_en[win.grp];

  always_comb begin
    irq_d = 1'b0;
    fiq_d = 1'b0;
    hp_d  = NO_IRQ;
    line  = 1'b0;
    if ((|dist_en) && (|cpu_en) && (win.prio < {1'b0, pmask})) begin
      hp_d = win.id;
      line = (win.prio < running) && grp_ok;
      if (line) begin
        if (!win.grp && fiq_en) fiq_d = 1'b1;
        else                    irq_d = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import arb_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          src_enable,
  input  logic [NUM_SRC-1:0]          src_pending,
  input  logic [NUM_SRC-1:0]          src_group,
  input  logic [NUM_SRC*8-1:0]        src_prio,
  input  logic [NUM_SRC*NUM_CPU-1:0]  src_target,
  input  logic [1:0]                  dist_grp_en,
  input  logic [NUM_CPU*2-1:0]        cpu_grp_en,
  input  logic [NUM_CPU-1:0]          cpu_fiq_en,
  input  logic [NUM_CPU*8-1:0]        cpu_pmask,
  input  logic [NUM_CPU*9-1:0]        cpu_running,
  output logic [NUM_CPU-1:0]          irq_o,
  output logic [NUM_CPU-1:0]          fiq_o,
  output logic [NUM_CPU*10-1:0]       hp_id
);
  logic [NUM_CPU-1:0]      irq_d, fiq_d;
  logic [NUM_CPU*ID_W-1:0] hp_d;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] tgt_col;
    winner_t            win;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
      assign tgt_col[s] = src_target[s*NUM_CPU + c];
    end

    arb_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .en      (src_enable),
      .pend    (src_pending),
      .grp     (src_group),
      .prio    (src_prio),
      .tgt_col (tgt_col),
      .win     (win)
    );

    arb_gate u_gate (
      .win     (win),
      .dist_en (dist_grp_en),
      .cpu_en  (cpu_grp_en[c*2 +: 2]),
      .fiq_en  (cpu_fiq_en[c]),
      .pmask   (cpu_pmask[c*PRIO_W +: PRIO_W]),
      .running (cpu_running[c*RUN_W +: RUN_W]),
      .irq_d   (irq_d[c]),
      .fiq_d   (fiq_d[c]),
      .hp_d    (hp_d[c*ID_W +: ID_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= '0;
      fiq_o <= '0;
      hp_id <= {NUM_CPU{NO_IRQ}};
    end else begin
      irq_o <= irq_d;
      fiq_o <= fiq_d;
      hp_id <= hp_d;
    end
  end
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            dist_grp_en,
  input logic [NUM_CPU*2-1:0]  cpu_grp_en,
  input logic [NUM_CPU-1:0]    cpu_fiq_en,
  input logic [NUM_CPU*8-1:0]  cpu_pmask,
  input logic [NUM_CPU*9-1:0]  cpu_running,
  input logic [NUM_CPU-1:0]    irq_o,
  input logic [NUM_CPU-1:0]    fiq_o,
  input logic [NUM_CPU*10-1:0] hp_id
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    // R9
    line_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_o[c] && fiq_o[c]));
    // R6
    line_needs_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[c] || fiq_o[c]) |-> (hp_id[c*10 +: 10] != 10'd1023));
    // R2
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_id[c*10 +: 10] != 10'd1023) |-> (int'(hp_id[c*10 +: 10]) < NUM_SRC));
    // R3
    dist_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dist_grp_en == 2'b00) || (cpu_grp_en[c*2 +: 2] == 2'b00)) |=>
        (!irq_o[c] && !fiq_o[c] && hp_id[c*10 +: 10] == 10'd1023));
    // R9
    fiq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_fiq_en[c] |=> !fiq_o[c]);
    // R7
    run_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_running[c*9 +: 9] == 9'd0) |=> (!irq_o[c] && !fiq_o[c]));
    // R6
    pmask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_pmask[c*8 +: 8] == 8'd0) |=> (hp_id[c*10 +: 10] == 10'd1023));
  end
endmodule

bind irq_prio_arb arb_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dist_grp_en (dist_grp_en),
  .cpu_grp_en  (cpu_grp_en),
  .cpu_fiq_en  (cpu_fiq_en),
  .cpu_pmask   (cpu_pmask),
  .cpu_running (cpu_running),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .hp_id       (hp_id)
);

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb;
  localparam int NS = 64;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NS-1:0]    en, pend, grp;
  logic [NS*8-1:0]  prio;
  logic [NS*NC-1:0] tgt;
  logic [1:0]       dge;
  logic [NC*2-1:0]  cge;
  logic [NC-1:0]    fe;
  logic [NC*8-1:0]  pm;
  logic [NC*9-1:0]  rp;
  logic [NC-1:0]    irq, fiq;
  logic [NC*10-1:0] hp;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_prio_arb #(.NUM_SRC(NS), .NUM_CPU(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_enable(en), .src_pending(pend),
    .src_group(grp), .src_prio(prio), .src_target(tgt), .dist_grp_en(dge),
    .cpu_grp_en(cge), .cpu_fiq_en(fe), .cpu_pmask(pm), .cpu_running(rp),
    .irq_o(irq), .fiq_o(fiq), .hp_id(hp)
  );

  function automatic logic [11:0] model(int c);
    logic [8:0] best = 9'h100;
    logic [9:0] id   = 10'd1023;
    logic       g    = 1'b0;
    logic       i    = 1'b0;
    logic       f    = 1'b0;
    logic [9:0] h    = 10'd1023;
    if (dge == 2'b00 || cge[c*2 +: 2] == 2'b00) return {2'b00, 10'd1023};
    for (int s = 0; s < NS; s++)
      if (en[s] && pend[s] && (s < 32 || tgt[s*NC+c]) &&
          {1'b0, prio[s*8 +: 8]} < best) begin
        best = {1'b0, prio[s*8 +: 8]}; id = 10'(s); g = grp[s];
      end
    if (best < {1'b0, pm[c*8 +: 8]}) begin
      h = id;
      if (best < rp[c*9 +: 9] && dge[g] && cge[c*2+g]) begin
        if (!g && fe[c]) f = 1'b1; else i = 1'b1;
      end
    end
    return {i, f, h};
  endfunction

  task automatic check(int c, string tag, logic [11:0] exp);
    logic [11:0] act = {irq[c], fiq[c], hp[c*10 +: 10]};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cpu%0d: got irq=%b fiq=%b id=%0d, expected irq=%b fiq=%b id=%0d",
               tag, c, act[11], act[10], act[9:0], exp[11], exp[10], exp[9:0]);
    end
  endtask

  task automatic clr_all();
    en = '0; pend = '0; grp = '0; prio = '1; tgt = '0;
    dge = 2'b11; cge = '1; fe = '0; pm = '1; rp = {NC{9'h100}};
  endtask

  task automatic add_src(int s, logic [7:0] p, logic g, logic [NC-1:0] t);
    en[s] = 1'b1; pend[s] = 1'b1; grp[s] = g; prio[s*8 +: 8] = p;
    for (int c = 0; c < NC; c++) tgt[s*NC+c] = t[c];
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clr_all();
    add_src(40, 8'h10, 1'b0, 2'b11);
    repeat (3) @(negedge clk);
    // R1: reset state even with a pending source
    for (int c = 0; c < NC; c++) check(c, "R1", {2'b00, 10'd1023});
    rst_n = 1'b1;
    clr_all();
    step();
    step();
    // R2: nothing pending
    for (int c = 0; c < NC; c++) check(c, "R2", {2'b00, 10'd1023});

    // R5: priority order and tie on lowest ID
    clr_all();
    add_src(40, 8'h30, 1'b0, 2'b11);
    add_src(35, 8'h30, 1'b0, 2'b11);
    add_src(50, 8'h20, 1'b0, 2'b01);
    step();
    check(0, "R5", {2'b10, 10'd50});
    check(1, "R5", {2'b10, 10'd35});

    // R4: private source ignores target, shared needs target bit
    clr_all();
    add_src(5, 8'h10, 1'b0, 2'b00);
    add_src(33, 8'h08, 1'b0, 2'b10);
    step();
    check(0, "R4", {2'b10, 10'd5});
    check(1, "R4", {2'b10, 10'd33});

    // R6: strict comparison against priority mask
    clr_all();
    add_src(60, 8'h40, 1'b0, 2'b11);
    pm = {8'h41, 8'h40};
    step();
    check(0, "R6", {2'b00, 10'd1023});
    check(1, "R6", {2'b10, 10'd60});

    // R7: strict comparison against running priority
    clr_all();
    add_src(60, 8'h40, 1'b0, 2'b11);
    rp = {9'h041, 9'h040};
    step();
    check(0, "R7", {2'b00, 10'd60});
    check(1, "R7", {2'b10, 10'd60});

    // R8: winner group must be enabled in distributor and CPU
    clr_all();
    add_src(60, 8'h40, 1'b1, 2'b11);
    cge = {2'b10, 2'b01};
    step();
    check(0, "R8", {2'b00, 10'd60});
    check(1, "R8", {2'b10, 10'd60});
    cge = '1; dge = 2'b01;
    step();
    check(1, "R8", {2'b00, 10'd60});

    // R9: group 0 steered to FIQ only where enabled
    clr_all();
    add_src(60, 8'h40, 1'b0, 2'b11);
    fe = 2'b01;
    step();
    check(0, "R9", {2'b01, 10'd60});
    check(1, "R9", {2'b10, 10'd60});

    // R3: distributor or CPU with no group enabled
    dge = 2'b00;
    step();
    for (int c = 0; c < NC; c++) check(c, "R3", {2'b00, 10'd1023});
    dge = 2'b11; cge = {2'b11, 2'b00};
    step();
    check(0, "R3", {2'b00, 10'd1023});
    check(1, "R3", {2'b10, 10'd60});

    // R10: change is invisible before the edge, visible after one edge
    clr_all();
    add_src(45, 8'h22, 1'b0, 2'b11);
    step();
    add_src(12, 8'h11, 1'b0, 2'b00);
    #2;
    check(0, "R10", {2'b10, 10'd45});
    step();
    check(0, "R10", {2'b10, 10'd12});

    // R5: random sweep with coarse priorities to force ties
    for (int k = 0; k < 400; k++) begin
      for (int s = 0; s < NS; s++) begin
        en[s]   = ($urandom % 4) != 0;
        pend[s] = ($urandom % 3) == 0;
        grp[s]  = $urandom % 2;
        prio[s*8 +: 8] = 8'(($urandom % 8) << 5);
      end
      for (int b = 0; b < NS*NC; b++) tgt[b] = $urandom % 2;
      dge = ($urandom % 8 == 0) ? 2'(($urandom % 4)) : 2'b11;
      for (int c = 0; c < NC; c++) begin
        cge[c*2 +: 2] = ($urandom % 8 == 0) ? 2'(($urandom % 4)) : 2'b11;
        fe[c] = $urandom % 2;
        pm[c*8 +: 8] = ($urandom % 2) ? 8'hFF : 8'($urandom);
        rp[c*9 +: 9] = ($urandom % 2) ? 9'h100 : 9'(($urandom % 8) << 5);
      end
      step();
      for (int c = 0; c < NC; c++) check(c, "R5", model(c));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule